// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave for a Thermal Monitor

This block is the serial-bus front end of a temperature monitor. It watches an SMBus/I2C clock and data pair using a fast system clock. It pulls the data line low through an output-enable, so the line stays open-drain. Behind the bus it holds an 8-bit pointer and eight 16-bit registers:

- capability
- configuration
- upper alarm limit
- lower alarm limit
- critical limit
- temperature
- maker identifier
- device identifier

A host write starts with a pointer byte. Up to two data bytes may follow, most significant first. A host read returns the word the pointer selects, high byte first. The host can read directly, or after a pointer write and a repeated start.

The configuration word and the three limits leave the block on ports for the event logic elsewhere on the chip. The temperature word and the event-status flag come in on ports. Two write-lock bits guard the limits and part of the configuration until reset. The device address uses three strap inputs, and their value is frozen only on the second transfer that addresses the device. If the data line goes quiet for too long, a timeout lets go of the bus.

Top module: `thermo_i2c_regfile`

## Requirements
- R1: The device answers the 7-bit address formed by the bits 0011 followed by strap bits [2:0]. It pulls SDA low in the ninth clock only for that address and ignores the rest of a transfer to any other address.
- R2: Before the freeze, address matching uses the live strap pins. The strap value is captured at the eighth clock of the second transfer whose address matched. After that, strap changes have no effect on which address is answered.
- R3: The pointer resets to 0x00. The first byte after a matched write address loads the pointer, and a write holding only that byte changes nothing else. A pointer with any of bits [7:3] set reads as 0x0000 and ignores writes.
- R4: A data write takes the high byte, then the low byte, and changes the register only once both bytes have arrived. Further bytes are acknowledged and discarded. A write stopped after one data byte leaves the register unchanged.
- R5: A read returns the word selected by the latched pointer, high byte first. It works either as a direct read or after a pointer write and a repeated start. A host NACK ends the read.
- R6: Values after reset are as follows:
  - capability 0x001D
  - configuration 0x0000
  - all three limits 0x0000
  - maker identifier 0x11D4
  - device identifier 0x0801
- R7: The configuration bits are as follows:
  - Bit 6 is the alarm lock. Once it is set, writes to the upper limit (pointer 2) and the lower limit (pointer 3) are ignored.
  - Bit 7 is the critical lock. Once it is set, writes to the critical limit (pointer 4) are ignored.
  - A written 0 never clears either lock. Only reset clears them.
- R8: While either lock is set, configuration bits [3:0] keep their value and bit 8 (shutdown) cannot go from 0 to 1. Bit 8 can still be cleared, and bits [10:9] stay writable.
- R9: Writing 1 to configuration bit 5 gives a one-cycle pulse on `clr_evt_o`, and bit 5 always reads 0. Configuration bit 4 reads `evt_stat_i`. Writes to capability (0), temperature (5), maker ID (6) and device ID (7) are ignored.
- R10: Each limit keeps only bits [12:2], so bits [15:13] and [1:0] read and export as 0. Configuration bits [15:11] read as 0.
- R11: If SDA does not change for `TIMEOUT_CYC` system clocks while a transfer is in progress, the slave releases SDA. It then waits for a new start condition.
- R12: A stop condition, even in the middle of a byte, returns the slave to idle. Register 5 (pointer 5) reads the live `temp_i` word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| strap_i | input | 3 | Address strap pins, low address bits |
| temp_i | input | 16 | Temperature word presented at pointer 5 |
| evt_stat_i | input | 1 | Event-status flag, read as configuration bit 4 |
| cfg_o | output | 16 | Stored configuration word |
| upper_o | output | 16 | Upper alarm limit |
| lower_o | output | 16 | Lower alarm limit |
| crit_o | output | 16 | Critical limit |
| clr_evt_o | output | 1 | One-cycle pulse for a clear-event write |

## Verification
The checker assumes the following about the bus:
- Each SCL high and low phase lasts several system clocks, enough to clear the two-flop synchronisers.
- SDA changes only while SCL is low, except at start and stop conditions.

It also assumes that reset is the only way the locks may fall.

The bench master holds every bus phase for four system clocks and moves SDA only in the low phase. The one exception is the timeout case, where it deliberately parks SCL low while the slave is acknowledging.

// File: rtl/thermo_i2c_regfile.sv
module thermo_i2c_regfile #(
  parameter int          TIMEOUT_CYC = 20_000_000,
  parameter logic [3:0]  ADDR_HI     = 4'b0011,
  parameter logic [15:0] CAP_VAL     = 16'h001D,
  parameter logic [15:0] MFG_VAL     = 16'h11D4,
  parameter logic [15:0] DEV_VAL     = 16'h0801
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  strap_i,
  input  logic [15:0] temp_i,
  input  logic        evt_stat_i,
  output logic [15:0] cfg_o,
  output logic [15:0] upper_o,
  output logic [15:0] lower_o,
  output logic [15:0] crit_o,
  output logic        clr_evt_o
);
  localparam int          TW       = $clog2(TIMEOUT_CYC + 1);
  localparam logic [15:0] THR_MASK = 16'h1FFC;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK1, S_ACK2, S_TX, S_MACK} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, ptr, msb_hold, txsh;
  logic [15:0]   txword, rd_mux, cfg_r;
  logic          is_addr, rw, lsb_next, mack_ok, frozen, seen1;
  logic [1:0]    wcnt;
  logic [2:0]    addr_lat;
  logic [TW-1:0] to_cnt;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] byte_in = {shreg[6:0], sda_s};
  wire [2:0] cur_strap = frozen ? addr_lat : strap_i;
  wire addr_hit = byte_in[7:1] == {ADDR_HI, cur_strap};
  wire ptr_ok   = ptr[7:3] == 5'd0;
  wire timeout  = (st != S_IDLE) && (to_cnt == TW'(TIMEOUT_CYC - 1));
  wire byte_end = (st == S_RX) && scl_rise && (bitcnt == 4'd7);
  wire wr_en    = byte_end && !is_addr && (wcnt == 2'd2) && ptr_ok;
  wire [15:0] wdata = {msb_hold, byte_in};
  wire locked   = cfg_r[6] | cfg_r[7];
  wire [15:0] rd_word = ptr_ok ? rd_mux : 16'h0000;
  wire [7:0]  nxt_byte = lsb_next ? txword[7:0] : txword[15:8];

  assign cfg_o = cfg_r;

  always_comb begin
    case (ptr[2:0])
      3'd0:    rd_mux = CAP_VAL;
      3'd1:    rd_mux = {5'd0, cfg_r[10:6], 1'b0, evt_stat_i, cfg_r[3:0]};
      3'd2:    rd_mux = upper_o;
      3'd3:    rd_mux = lower_o;
      3'd4:    rd_mux = crit_o;
      3'd5:    rd_mux = temp_i;
      3'd6:    rd_mux = MFG_VAL;
      default: rd_mux = DEV_VAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;              sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             to_cnt <= '0;
    else if (st == S_IDLE || sda_s != sda_q) to_cnt <= '0;
    else if (!timeout)                      to_cnt <= to_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= '0; upper_o <= '0; lower_o <= '0; crit_o <= '0; clr_evt_o <= 1'b0;
    end else begin
      clr_evt_o <= wr_en && (ptr[2:0] == 3'd1) && wdata[5];
      if (wr_en) begin
        case (ptr[2:0])
          3'd1: begin
            cfg_r[3:0]   <= locked ? cfg_r[3:0] : wdata[3:0];
            cfg_r[6]     <= cfg_r[6] | wdata[6];
            cfg_r[7]     <= cfg_r[7] | wdata[7];
            cfg_r[8]     <= locked ? (cfg_r[8] & wdata[8]) : wdata[8];
            cfg_r[10:9]  <= wdata[10:9];
          end
          3'd2: if (!cfg_r[6]) upper_o <= wdata & THR_MASK;
          3'd3: if (!cfg_r[6]) lower_o <= wdata & THR_MASK;
          3'd4: if (!cfg_r[7]) crit_o  <= wdata & THR_MASK;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0; msb_hold <= '0;
      txsh <= '0; txword <= '0; is_addr <= 1'b0; rw <= 1'b0; lsb_next <= 1'b0;
      mack_ok <= 1'b0; frozen <= 1'b0; seen1 <= 1'b0; wcnt <= '0;
      addr_lat <= '0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_RX; is_addr <= 1'b1; bitcnt <= '0; wcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c || timeout) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX: if (scl_rise) begin
          shreg  <= byte_in;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 4'd7) begin
            if (is_addr) begin
              if (addr_hit) begin
                rw     <= byte_in[0];
                txword <= rd_word;
                st     <= S_ACK1;
                if (!frozen) begin
                  if (seen1) begin frozen <= 1'b1; addr_lat <= strap_i; end
                  seen1 <= 1'b1;
                end
              end else st <= S_IDLE;
            end else begin
              st <= S_ACK1;
              if (wcnt == 2'd0) ptr <= byte_in;
              if (wcnt == 2'd1) msb_hold <= byte_in;
              if (wcnt != 2'd3) wcnt <= wcnt + 1'b1;
            end
          end
        end
        S_ACK1: if (scl_fall) begin sda_oe <= 1'b1; st <= S_ACK2; end
        S_ACK2: if (scl_fall) begin
          bitcnt <= '0;
          if (is_addr && rw) begin
            txsh <= txword[15:8]; sda_oe <= ~txword[15]; lsb_next <= 1'b1; st <= S_TX;
          end else begin
            sda_oe <= 1'b0; is_addr <= 1'b0; st <= S_RX;
          end
        end
        S_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin sda_oe <= 1'b0; st <= S_MACK; end
            else begin txsh <= {txsh[6:0], 1'b0}; sda_oe <= ~txsh[6]; end
          end
        end
        S_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          if (scl_fall) begin
            if (mack_ok) begin
              txsh <= nxt_byte; sda_oe <= ~nxt_byte[7]; lsb_next <= ~lsb_next;
              bitcnt <= '0; st <= S_TX;
            end else st <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module thermo_i2c_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cfg_o,
  input logic [15:0] upper_o,
  input logic [15:0] lower_o,
  input logic [15:0] crit_o,
  input logic        clr_evt_o
);
  assert_alarm_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[6] |=> $stable(upper_o) && $stable(lower_o));
  assert_crit_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7] |=> $stable(crit_o));
  assert_locks_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[6] |=> cfg_o[6]) and (cfg_o[7] |=> cfg_o[7]));
  assert_cfg_low_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o[6] || cfg_o[7]) |=> $stable(cfg_o[3:0]));
  assert_no_shdn_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_o[6] || cfg_o[7]) && !cfg_o[8]) |=> !cfg_o[8]);
  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt_o |=> !clr_evt_o);
  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (((upper_o | lower_o | crit_o) & 16'hE003) == 16'h0) && (cfg_o[15:11] == 5'd0));
endmodule

bind thermo_i2c_regfile thermo_i2c_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_o(cfg_o), .upper_o(upper_o),
  .lower_o(lower_o), .crit_o(crit_o), .clr_evt_o(clr_evt_o));

// File: tb/sim_thermo_i2c_regfile.sv
module sim_thermo_i2c_regfile;
  localparam int TO = 400;
  localparam logic [6:0] A = 7'h1A;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, evt = 1'b0;
  logic [2:0]  strap = 3'b011;
  logic [15:0] temp = 16'h0000;
  logic sda_oe, clr_evt;
  logic [15:0] cfg, upr, lwr, crt;
  wire  sda_ln = sda_m & ~sda_oe;
  int n_chk = 0, n_bad = 0, clr_cnt = 0;
  bit done = 0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  thermo_i2c_regfile #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln), .sda_oe(sda_oe),
    .strap_i(strap), .temp_i(temp), .evt_stat_i(evt), .cfg_o(cfg),
    .upper_o(upr), .lower_o(lwr), .crit_o(crt), .clr_evt_o(clr_evt));

  task automatic chk(input bit ok, input string t, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%h expected=%h", t, a, e); end
  endtask

  always @(negedge clk) begin
    if (clr_evt) clr_cnt++;
    if (act_q.size() > 0) begin
      logic [7:0] av, ev;
      string t;
      av = act_q.pop_front();
      ev = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      t  = (tag_q.size() > 0) ? tag_q.pop_front() : "unexpected";
      chk(av === ev, t, {24'd0, av}, {24'd0, ev});
    end
  end

  task automatic q(); repeat (4) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic bstop();  sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q(); endtask
  task automatic wbit(input logic b); sda_m = b; q(); scl_m = 1; q(); q(); scl_m = 0; q(); endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1; q(); scl_m = 1; q(); ack = !sda_ln; q(); scl_m = 0; q();
  endtask

  task automatic rbyte(input logic last);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; q(); scl_m = 1; q(); v = {v[6:0], sda_ln}; q(); scl_m = 0; q();
    end
    wbit(last); sda_m = 1;
    act_q.push_back(v);
  endtask

  task automatic expect_word(input logic [15:0] w, input string t);
    exp_q.push_back(w[15:8]); exp_q.push_back(w[7:0]);
    tag_q.push_back({t, " hi"}); tag_q.push_back({t, " lo"});
  endtask

  task automatic wr(input logic [7:0] p, input int n, input logic [23:0] d, input string t);
    bit ack;
    bstart(); wbyte({A, 1'b0}, ack); chk(ack, {t, " R1 addr ack"}, ack, 1);
    wbyte(p, ack); chk(ack, {t, " R3 ptr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(d[23-8*i -: 8], ack); chk(ack, {t, " R4 data ack"}, ack, 1);
    end
    bstop();
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] w, input string t);
    bit ack;
    expect_word(w, t);
    bstart(); wbyte({a, 1'b1}, ack); chk(ack, {t, " R1 read ack"}, ack, 1);
    rbyte(0); rbyte(1); bstop();
  endtask

  task automatic rdp(input logic [7:0] p, input logic [15:0] w, input string t);
    bit ack;
    expect_word(w, t);
    bstart(); wbyte({A, 1'b0}, ack); wbyte(p, ack);
    bstart(); wbyte({A, 1'b1}, ack); chk(ack, {t, " R5 rep-start ack"}, ack, 1);
    rbyte(0); rbyte(1); bstop();
  endtask

  task automatic probe(input logic [6:0] a, input bit exp_ack, input string t);
    bit ack;
    bstart(); wbyte({a, 1'b0}, ack); chk(ack == exp_ack, t, ack, exp_ack); bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    chk(cfg == 0 && upr == 0 && lwr == 0 && crt == 0, "R6 reset limits/cfg", {cfg, upr}, 0);
    chk(sda_ln == 1 && clr_evt == 0, "R6 bus released at reset", sda_ln, 1);

    rd(7'h1B, 16'h001D, "R2 live strap / R6 capability / R5 direct");
    strap = 3'b010;
    probe(7'h1B, 0, "R1 non-matching address nack");
    wr(8'h06, 0, 24'h0, "R2 second match freezes");
    strap = 3'b111;
    rd(A, 16'h11D4, "R2 frozen address / R6 maker id");
    probe(7'h1F, 0, "R2 later strap change ignored");
    rdp(8'h07, 16'h0801, "R6 device id");

    wr(8'h02, 2, 24'hFFFF00, "R10");
    chk(upr == 16'h1FFC, "R10 upper unused bits zero", upr, 16'h1FFC);
    rd(A, 16'h1FFC, "R10 upper readback");
    wr(8'h03, 3, 24'h0550AA, "R4 extra byte");
    chk(lwr == 16'h0550, "R4 extra byte ignored", lwr, 16'h0550);
    wr(8'h04, 1, 24'h120000, "R4 half write");
    chk(crt == 16'h0000, "R4 single byte no commit", crt, 0);
    rd(A, 16'h0000, "R3 pointer held at 4");
    temp = 16'hC190;
    wr(8'h05, 0, 24'h0, "R3 pointer only");
    rd(A, 16'hC190, "R12 temperature word");

    wr(8'h0A, 2, 24'h123400, "R3 reserved");
    chk(upr == 16'h1FFC, "R3 reserved write ignored", upr, 16'h1FFC);
    rd(A, 16'h0000, "R3 reserved reads zero");
    wr(8'h00, 2, 24'hFFFF00, "R9 ro");
    rdp(8'h00, 16'h001D, "R9 capability write ignored");

    evt = 1; c0 = clr_cnt;
    wr(8'h01, 2, 24'h002F00, "R9 clear");
    chk(clr_cnt == c0 + 1, "R9 clear pulse one cycle", clr_cnt - c0, 1);
    chk(cfg == 16'h000F, "R9 cfg stored", cfg, 16'h000F);
    rd(A, 16'h001F, "R9 status bit4 and clear bit5 read");
    evt = 0;

    wr(8'h01, 2, 24'h010F00, "R8");
    chk(cfg == 16'h010F, "R8 shutdown set unlocked", cfg, 16'h010F);
    wr(8'h01, 2, 24'h014F00, "R7");
    chk(cfg == 16'h014F, "R7 alarm lock set", cfg, 16'h014F);
    wr(8'h01, 2, 24'h000000, "R8");
    chk(cfg == 16'h004F, "R8 low bits kept, shutdown cleared, lock kept", cfg, 16'h004F);
    wr(8'h01, 2, 24'h010000, "R8");
    chk(cfg == 16'h004F, "R8 shutdown cannot set when locked", cfg, 16'h004F);
    wr(8'h02, 2, 24'h000000, "R7");
    chk(upr == 16'h1FFC, "R7 upper locked", upr, 16'h1FFC);
    wr(8'h03, 2, 24'h000000, "R7");
    chk(lwr == 16'h0550, "R7 lower locked", lwr, 16'h0550);
    wr(8'h04, 2, 24'h012300, "R7");
    chk(crt == 16'h0120, "R7 critical open before its lock", crt, 16'h0120);
    wr(8'h01, 2, 24'h00CF00, "R7");
    chk(cfg == 16'h00CF, "R7 critical lock set", cfg, 16'h00CF);
    wr(8'h04, 2, 24'h040000, "R7");
    chk(crt == 16'h0120, "R7 critical locked", crt, 16'h0120);
    wr(8'h01, 2, 24'h060000, "R8");
    chk(cfg == 16'h06CF, "R8 hysteresis writable, R7 locks sticky", cfg, 16'h06CF);

    bstart();
    for (int i = 7; i >= 0; i--) wbit(i == 0 ? 1'b0 : A[i-1]);
    sda_m = 1; q();
    chk(sda_ln == 0, "R11 ack held before timeout", sda_ln, 0);
    repeat (TO + 50) @(negedge clk);
    chk(sda_ln == 1, "R11 SDA released after timeout", sda_ln, 1);
    scl_m = 1; q();
    rd(A, 16'h06CF, "R11 recovery read");

    bstart(); wbit(0); wbit(0); wbit(1); wbit(1); bstop();
    rd(A, 16'h06CF, "R12 stop mid-byte returns idle");

    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
    chk(cfg == 0 && crt == 0, "R7 locks cleared by reset", cfg, 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && act_q.size() == 0, "R5 all read bytes compared", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule